// File: doc/BRIEF.md
# Level-Source Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of peripheral sources and raises one external-interrupt line toward a single processor core. Each source sets a sticky pending flag. Software gives every source a small priority value and an enable bit, and sets a global threshold. The line is raised only while a pending, enabled source has a priority above that threshold.

The core handles an interrupt in two steps. It reads the claim register, which returns the ID of the source held for service and clears that source's pending flag. When the handler has finished, it writes the same ID back to the claim register to release it. The held ID is captured by hardware. While no ID is held, the lowest-numbered source that qualifies is taken, and it stays held until the core releases it. ID 0 means that no source is held.

All registers sit behind a simple 32-bit word interface with a one-cycle registered read. The two low address bits are ignored.

Top module: `lvl_intc`

## Requirements
- R1: After reset, the threshold, the held claim ID, every pending bit, every enable bit and every priority are zero, and `irq_o` is low.
- R2: Read data appears on `bus_rdata_o` in the cycle after a read request. Pending flags are read at word addresses 0x000, 0x004 and 0x008. Enable bits are at 0x200, 0x204 and 0x208. In both arrays, source N uses word N/32, bit N%32, and bits for sources that do not exist read zero. The priority of source N is at 0x018 + 4*N. The threshold is at 0x20C and the claim register is at 0x210.
- R3: A priority register keeps bits 2:0 of the written value. The threshold keeps bits 1:0. All other bits of both read zero. The priority register of source 0 always reads zero.
- R4: A source input sampled high sets its pending bit at the next clock edge. The bit stays set after the input falls, until the source is claimed. Source 0 can never become pending.
- R5: The pending words are read-only, and writing them leaves every pending bit unchanged.
- R6: `irq_o` is high exactly when some source is pending and enabled and has a priority strictly greater than the threshold. It follows register writes and pending changes in the cycle after they take effect.
- R7: While the held ID is zero, the controller captures the lowest-numbered qualifying source one cycle after that source qualifies. The held ID does not change until it is completed, even when a lower-numbered source qualifies later.
- R8: Reading the claim register returns the held ID and clears that source's pending bit. A read while the held ID is zero returns 0.
- R9: Writing the claim register with a value equal to the held ID resets the held ID to zero. A write of any other value leaves the held ID unchanged.
- R10: The source-mode range 0x00C to 0x017 and every address outside the defined ranges read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level interrupt requests, bit N is source N |
| bus_sel_i | input | 1 | Register access request this cycle |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after a read |
| irq_o | output | 1 | External-interrupt request to the core |

## Verification
The bench builds the controller with its default parameters: 80 sources, 32-bit words, 3-bit priorities and a 2-bit threshold. With 80 sources the pending and enable arrays span three words, and the last word is only partly populated. This lets the bench check sources at word boundaries (32, 40, 64, 70, 79) and confirm that the unused upper enable bits read zero. With a 2-bit threshold under a 3-bit priority, the bench can check the strict comparison both at equality and one step below it.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

   typedef enum logic [2:0] {
      RGN_NONE,
      RGN_PEND,
      RGN_MODE,
      RGN_PRIO,
      RGN_EN,
      RGN_THR,
      RGN_CLAIM
   } region_e;

   function automatic int unsigned words_for(input int unsigned bits, input int unsigned w);
      return (bits + w - 1) / w;
   endfunction

endpackage

// File: rtl/lvl_intc_gateway.sv
module lvl_intc_gateway #(
   parameter int unsigned NUM_SRC = 80,
   parameter int unsigned ID_W    = $clog2(NUM_SRC)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               clr_i,
   input  logic [ID_W-1:0]    clr_id_i,
   output logic [NUM_SRC-1:0] pend_o
);

   assign pend_o[0] = 1'b0;

   for (genvar s = 1; s < NUM_SRC; s++) begin : g_src
      logic hit_clr;
      assign hit_clr = clr_i && (clr_id_i == ID_W'(s));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        pend_o[s] <= 1'b0;
         else if (hit_clr)   pend_o[s] <= 1'b0;
         else if (src_i[s])  pend_o[s] <= 1'b1;
      end

      // R4: a sampled high level, not cleared by a claim, leaves the bit set
      a_r4_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (src_i[s] || pend_o[s]) && !hit_clr |=> pend_o[s]);
   end

endmodule

// File: rtl/lvl_intc_select.sv
module lvl_intc_select #(
   parameter int unsigned NUM_SRC = 80,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned THR_W   = 2,
   parameter int unsigned ID_W    = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]             pend_i,
   input  logic [NUM_SRC-1:0]             en_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   input  logic [THR_W-1:0]               thr_i,
   output logic                           any_o,
   output logic [ID_W-1:0]                id_o
);

   logic [NUM_SRC-1:0] qual;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_qual
      assign qual[s] = pend_i[s] && en_i[s] && (prio_i[s] > PRIO_W'(thr_i));
   end

   assign any_o = |qual;

   always_comb begin
      id_o = '0;
      for (int s = NUM_SRC - 1; s >= 1; s--) begin
         if (qual[s]) id_o = ID_W'(s);
      end
   end

endmodule

// File: rtl/lvl_intc_regs.sv
module lvl_intc_regs
   import lvl_intc_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 80,
   parameter int unsigned PRIO_W     = 3,
   parameter int unsigned THR_W      = 2,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned PEND_BASE  = 'h000,
   parameter int unsigned MODE_BASE  = 'h00C,
   parameter int unsigned PRIO_BASE  = 'h018,
   parameter int unsigned EN_BASE    = 'h200,
   parameter int unsigned THR_BASE   = 'h20C,
   parameter int unsigned CLAIM_BASE = 'h210,
   parameter int unsigned ID_W       = $clog2(NUM_SRC)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic                           bus_sel_i,
   input  logic                           bus_we_i,
   input  logic [ADDR_W-1:0]              bus_addr_i,
   input  logic [DATA_W-1:0]              bus_wdata_i,
   output logic [DATA_W-1:0]              bus_rdata_o,
   input  logic [NUM_SRC-1:0]             pend_i,
   input  logic [ID_W-1:0]                claim_i,
   output logic [NUM_SRC-1:0]             en_o,
   output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
   output logic [THR_W-1:0]               thr_o,
   output logic                           claim_rd_o,
   output logic                           claim_wr_o
);

   localparam int unsigned WORDS   = words_for(NUM_SRC, DATA_W);
   localparam int unsigned PAD_W   = WORDS * DATA_W;
   localparam int unsigned BYTES_W = DATA_W / 8;

   logic        unused_lsb;
   logic [31:0] wi;
   region_e     region;
   logic [31:0] idx;
   logic [PAD_W-1:0]  pend_pad, en_pad;
   logic [DATA_W-1:0] rd_val;
   logic wr, rd;

   assign unused_lsb = ^bus_addr_i[1:0];
   assign wi = 32'(bus_addr_i[ADDR_W-1:2]);
   assign wr = bus_sel_i && bus_we_i;
   assign rd = bus_sel_i && !bus_we_i;

   // region decode via unsigned offsets, so no comparison can be constant
   always_comb begin
      region = RGN_NONE;
      idx    = '0;
      if ((wi - PEND_BASE / BYTES_W) < WORDS) begin
         region = RGN_PEND;
         idx    = wi - PEND_BASE / BYTES_W;
      end else if ((wi - MODE_BASE / BYTES_W) < WORDS) begin
         region = RGN_MODE;
      end else if ((wi - PRIO_BASE / BYTES_W) < NUM_SRC) begin
         region = RGN_PRIO;
         idx    = wi - PRIO_BASE / BYTES_W;
      end else if ((wi - EN_BASE / BYTES_W) < WORDS) begin
         region = RGN_EN;
         idx    = wi - EN_BASE / BYTES_W;
      end else if (wi == THR_BASE / BYTES_W) begin
         region = RGN_THR;
      end else if (wi == CLAIM_BASE / BYTES_W) begin
         region = RGN_CLAIM;
      end
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int unsigned W = s / DATA_W;
      localparam int unsigned B = s % DATA_W;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) en_o[s] <= 1'b0;
         else if (wr && region == RGN_EN && idx == 32'(W)) en_o[s] <= bus_wdata_i[B];
      end

      if (s == 0) begin : g_zero
         assign prio_o[s] = '0;
      end else begin : g_prio
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) prio_o[s] <= '0;
            else if (wr && region == RGN_PRIO && idx == 32'(s)) prio_o[s] <= bus_wdata_i[PRIO_W-1:0];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) thr_o <= '0;
      else if (wr && region == RGN_THR) thr_o <= bus_wdata_i[THR_W-1:0];
   end

   assign pend_pad   = PAD_W'(pend_i);
   assign en_pad     = PAD_W'(en_o);
   assign claim_rd_o = rd && region == RGN_CLAIM;
   assign claim_wr_o = wr && region == RGN_CLAIM;

   always_comb begin
      rd_val = '0;
      unique case (region)
         RGN_PEND: for (int w = 0; w < WORDS; w++)
                      if (idx == 32'(w)) rd_val = pend_pad[w*DATA_W +: DATA_W];
         RGN_EN:   for (int w = 0; w < WORDS; w++)
                      if (idx == 32'(w)) rd_val = en_pad[w*DATA_W +: DATA_W];
         RGN_PRIO: for (int s = 0; s < NUM_SRC; s++)
                      if (idx == 32'(s)) rd_val = DATA_W'(prio_o[s]);
         RGN_THR:   rd_val = DATA_W'(thr_o);
         RGN_CLAIM: rd_val = DATA_W'(claim_i);
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bus_rdata_o <= '0;
      else if (rd) bus_rdata_o <= rd_val;
   end

   // R3: a threshold write keeps only the low bits of the data
   a_r3_thr_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr && region == RGN_THR |=> thr_o == $past(bus_wdata_i[THR_W-1:0]));

   // R10: a write to the source-mode range leaves the threshold alone
   a_r10_mode_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr && region == RGN_MODE |=> $stable(thr_o) && $stable(en_o));

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
   import lvl_intc_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 80,
   parameter int unsigned PRIO_W     = 3,
   parameter int unsigned THR_W      = 2,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned PEND_BASE  = 'h000,
   parameter int unsigned MODE_BASE  = 'h00C,
   parameter int unsigned PRIO_BASE  = 'h018,
   parameter int unsigned EN_BASE    = 'h200,
   parameter int unsigned THR_BASE   = 'h20C,
   parameter int unsigned CLAIM_BASE = 'h210
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_sel_i,
   input  logic               bus_we_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               irq_o
);

   localparam int unsigned ID_W  = $clog2(NUM_SRC);
   localparam int unsigned WORDS = words_for(NUM_SRC, DATA_W);
   localparam int unsigned BYTES = DATA_W / 8;

   if (NUM_SRC < 2 || NUM_SRC > 1023) begin : g_bad_src
      $error("NUM_SRC out of range");
   end
   if (THR_W > PRIO_W || PRIO_W > DATA_W) begin : g_bad_prio
      $error("threshold must not be wider than priority");
   end
   if (DATA_W % 8 != 0 || ID_W > DATA_W) begin : g_bad_data
      $error("DATA_W must be whole bytes and hold an ID");
   end
   if (PEND_BASE + WORDS * BYTES > MODE_BASE || MODE_BASE + WORDS * BYTES > PRIO_BASE ||
       PRIO_BASE + NUM_SRC * BYTES > EN_BASE || EN_BASE + WORDS * BYTES > THR_BASE ||
       THR_BASE >= CLAIM_BASE || CLAIM_BASE >= (1 << ADDR_W)) begin : g_bad_map
      $error("register ranges overlap or exceed the address space");
   end

   logic [NUM_SRC-1:0]             pend;
   logic [NUM_SRC-1:0]             en;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
   logic [THR_W-1:0]               thr;
   logic                           claim_rd, claim_wr, any_qual, complete;
   logic [ID_W-1:0]                pick_id, claim_q;

   lvl_intc_regs #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .THR_W(THR_W), .DATA_W(DATA_W),
      .ADDR_W(ADDR_W), .PEND_BASE(PEND_BASE), .MODE_BASE(MODE_BASE),
      .PRIO_BASE(PRIO_BASE), .EN_BASE(EN_BASE), .THR_BASE(THR_BASE),
      .CLAIM_BASE(CLAIM_BASE), .ID_W(ID_W)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
      .pend_i(pend), .claim_i(claim_q),
      .en_o(en), .prio_o(prio), .thr_o(thr),
      .claim_rd_o(claim_rd), .claim_wr_o(claim_wr)
   );

   lvl_intc_gateway #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_gateway (
      .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
      .clr_i(claim_rd && claim_q != '0), .clr_id_i(claim_q), .pend_o(pend)
   );

   lvl_intc_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .THR_W(THR_W), .ID_W(ID_W)) u_select (
      .pend_i(pend), .en_i(en), .prio_i(prio), .thr_i(thr),
      .any_o(any_qual), .id_o(pick_id)
   );

   assign complete = claim_wr && claim_q != '0 && bus_wdata_i == DATA_W'(claim_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       claim_q <= '0;
      else if (complete)                 claim_q <= '0;
      else if (claim_q == '0 && any_qual) claim_q <= pick_id;
   end

   assign irq_o = any_qual;

   // decode of the pending range, kept apart from the register block for checking
   logic        pend_wr;
   logic [31:0] pend_off;
   assign pend_off = 32'(bus_addr_i[ADDR_W-1:2]) - PEND_BASE / BYTES;
   assign pend_wr  = bus_sel_i && bus_we_i && pend_off < WORDS;

   // R5: a write to the pending words clears no pending bit
   a_r5_pend_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_wr |=> (pend & $past(pend)) == $past(pend));

   // R8: a claim read drops the pending bit of the held source
   a_r8_claim_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_rd && claim_q != '0 |=> !pend[$past(claim_q)]);

   // R9: matching completion releases the held ID
   a_r9_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
      complete |=> claim_q == '0);

   // R9: a mismatching completion is ignored
   a_r9_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_wr && claim_q != '0 && bus_wdata_i != DATA_W'(claim_q) |=> $stable(claim_q));

   // R7: a held ID stays put until completion
   a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_q != '0 && !claim_wr |=> $stable(claim_q));

endmodule

// File: tb/lvl_intc_bench.sv
module lvl_intc_bench;

   localparam int N = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] src = '0;
   logic        sel = 1'b0, we = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   lvl_intc u_lvl_intc (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src),
      .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      sel = 1'b0;
      d = rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; src = '0; sel = 1'b0; we = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      chk("R1 irq", 32'(irq), 0);
      rd(10'h000, d); chk("R1 pending word0", d, 0);
      rd(10'h208, d); chk("R1 enable word2", d, 0);
      rd(10'h054, d); chk("R1 priority src15", d, 0);
      rd(10'h20C, d); chk("R1 threshold", d, 0);
      rd(10'h210, d); chk("R1 claim", d, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      do_reset();
      wr(10'h01C, 32'hFF);       rd(10'h01C, d); chk("R3 priority src1 masked", d, 7);
      wr(10'h154, 32'h5);        rd(10'h154, d); chk("R2 priority src79", d, 5);
      wr(10'h018, 32'h7);        rd(10'h018, d); chk("R3 priority src0 zero", d, 0);
      wr(10'h20C, 32'hF);        rd(10'h20C, d); chk("R3 threshold masked", d, 3);
      wr(10'h208, 32'hFFFF_FFFF); rd(10'h208, d); chk("R2 enable word2 partial", d, 32'h0000_FFFF);
      wr(10'h200, 32'hA5A5_A5A5); rd(10'h200, d); chk("R2 enable word0", d, 32'hA5A5_A5A5);
      rd(10'h01D, d); chk("R2 low address bits ignored", d, 7);
   endtask

   task automatic t_pending();
      logic [31:0] d;
      do_reset();
      @(negedge clk);
      src[0] = 1'b1; src[5] = 1'b1; src[32] = 1'b1; src[79] = 1'b1;
      @(negedge clk);
      src = '0;
      idle(1);
      rd(10'h000, d); chk("R4 pending word0 src5 no src0", d, 32'h20);
      rd(10'h004, d); chk("R4 pending word1 src32", d, 32'h1);
      rd(10'h008, d); chk("R4 pending word2 src79", d, 32'h8000);
      wr(10'h000, 32'hFFFF_FFFF);
      wr(10'h004, 32'h0);
      rd(10'h000, d); chk("R5 pending word0 after write", d, 32'h20);
      rd(10'h004, d); chk("R5 pending word1 after write", d, 32'h1);
   endtask

   task automatic t_irq();
      do_reset();
      wr(10'h200, 32'h400);      // enable source 10
      wr(10'h040, 32'h2);        // priority of source 10
      wr(10'h20C, 32'h2);
      @(negedge clk); src[10] = 1'b1;
      @(negedge clk); src[10] = 1'b0;
      chk("R6 irq low at priority equal threshold", 32'(irq), 0);
      wr(10'h20C, 32'h1);
      chk("R6 irq high above threshold", 32'(irq), 1);
      wr(10'h200, 32'h0);
      chk("R6 irq low when disabled", 32'(irq), 0);
      wr(10'h200, 32'h400);
      wr(10'h20C, 32'h0);
      chk("R6 irq high threshold zero", 32'(irq), 1);
      wr(10'h040, 32'h0);
      chk("R6 irq low priority zero", 32'(irq), 0);
   endtask

   task automatic t_claim();
      logic [31:0] d;
      do_reset();
      wr(10'h024, 32'h1);        // source 3
      wr(10'h0B8, 32'h1);        // source 40
      wr(10'h130, 32'h1);        // source 70
      wr(10'h200, 32'h8);
      wr(10'h204, 32'h100);
      wr(10'h208, 32'h40);
      @(negedge clk); src[40] = 1'b1; src[70] = 1'b1;
      @(negedge clk); src = '0;
      idle(2);
      @(negedge clk); src[3] = 1'b1;
      @(negedge clk); src = '0;
      idle(2);
      rd(10'h210, d); chk("R7 lowest qualifying held, not replaced", d, 40);
      rd(10'h004, d); chk("R8 claim read clears src40", d, 0);
      rd(10'h000, d); chk("R8 other pending kept", d, 32'h8);
      wr(10'h210, 32'd70);
      idle(1);
      rd(10'h210, d); chk("R9 wrong ID ignored", d, 40);
      wr(10'h210, 32'd40);
      idle(2);
      rd(10'h210, d); chk("R7 next capture after completion", d, 3);
      chk("R6 irq with src70 still pending", 32'(irq), 1);
      wr(10'h210, 32'd3);
      idle(2);
      rd(10'h210, d); chk("R7 capture src70", d, 70);
      wr(10'h210, 32'd70);
      idle(2);
      chk("R6 irq low when nothing pending", 32'(irq), 0);
      rd(10'h210, d); chk("R8 empty claim reads zero", d, 0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      do_reset();
      wr(10'h20C, 32'h2);
      wr(10'h00C, 32'hFFFF_FFFF);
      rd(10'h00C, d); chk("R10 mode word reads zero", d, 0);
      rd(10'h014, d); chk("R10 last mode word reads zero", d, 0);
      wr(10'h300, 32'h1);
      wr(10'h214, 32'h3);
      rd(10'h300, d); chk("R10 unmapped reads zero", d, 0);
      rd(10'h20C, d); chk("R10 threshold untouched", d, 2);
      rd(10'h200, d); chk("R10 enable untouched", d, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      t_reset();
      t_regs();
      t_pending();
      t_irq();
      t_claim();
      t_unmapped();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule